// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This engine sends frames that software has placed in memory as a chain of linked transmit descriptors. Each descriptor takes four 32-bit words and gives a byte count, a command/status word, the address of the following descriptor and the address of its data buffer. Software writes a descriptor address into the engine's current-pointer register and pulses the start command. The engine then reads each descriptor through a word-wide memory port and streams the buffer bytes in order on a byte output with valid/ready handshaking. When it reaches the descriptor that ends the frame, it hands the descriptors back to software by clearing their ownership bits.

After each frame the current pointer moves to the next pointer of the last descriptor processed. The engine then starts the following frame on its own, and stops when it finds a first descriptor it does not own. If a chain has a null next pointer before its closing descriptor, the frame is aborted. The final byte of an aborted frame is flagged so the consumer can drop the frame, no buffer-sent cause is raised, and the engine raises the end cause and drops its start bit.

The output holds each byte back by one position. This lets the last-byte marker sit on the true final byte even when the closing descriptors carry no data.

Top module: `tdma_tx_engine`

## Requirements
- R1: After reset, `start_bit`, `cur_ptr`, `tx_valid`, `mem_req_valid` and both cause outputs are 0.
- R2: When the start command is given with `cur_ptr` equal to zero, the engine makes no memory request, streams nothing and raises no cause.
- R3: When the first descriptor's OWN bit (command/status bit 31) is clear, the engine streams nothing, writes nothing, raises no cause and leaves `cur_ptr` unchanged.
- R4: A descriptor's byte count is bits 31:16 of the word at offset 0, and its low 16 bits are ignored. That many bytes are read starting at the buffer pointer (offset 12), at any byte alignment. The byte at address A is found in lane A mod 4 of the word at A with its two low bits cleared, and lane k is bits 8k+7:8k.
- R5: Bytes leave on `tx_data` in buffer order and descriptor order, and `tx_last` is 1 on the final byte of each frame only. While `tx_ready` is low, `tx_valid` and `tx_data` hold steady. A memory request holds until `mem_req_ready` accepts it.
- R6: Every descriptor in a frame other than the first has its command/status word (offset 4) written back with bit 31 cleared and all other bits kept, once its data has been read.
- R7: The first descriptor's command/status word is written back with bit 31 cleared after the frame ends, whether or not the frame was aborted.
- R8: A frame ends at the descriptor whose command/status bit 30 (last) is set. The next-descriptor pointer is the word at offset 8.
- R9: A zero next pointer on a descriptor without the last bit aborts the frame. Its final streamed byte carries `tx_abort` together with `tx_last`, and `cause_txbuf` is not raised.
- R10: `cause_txbuf` pulses for one cycle once per frame that had a non-zero total length and was not aborted. A frame whose total length is zero streams nothing and raises no `cause_txbuf`.
- R11: At frame end `cur_ptr` takes the next pointer of the last descriptor processed. If that pointer is zero, or the frame was aborted, `cause_txend` pulses and `start_bit` reads 0 on the following cycle.
- R12: After a frame ends without the end cause, the engine goes on to the frame at the new `cur_ptr` without a new start command. It stops at a first descriptor it does not own.
- R13: A `ptr_load` pulse sets `cur_ptr` to `ptr_value`, and a `cmd_start` pulse sets `start_bit`. Each is visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start command pulse |
| ptr_load | input | 1 | Load pulse for the current descriptor pointer |
| ptr_value | input | ADDR_W | Value loaded into the current pointer |
| start_bit | output | 1 | Start command bit, cleared by the end cause |
| cur_ptr | output | ADDR_W | Current descriptor pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_abort | output | 1 | Frame aborted, drop it (only with tx_last) |
| cause_txbuf | output | 1 | One-cycle pulse: frame sent |
| cause_txend | output | 1 | One-cycle pulse: chain ended or aborted |

## Verification
The pointer load and the start bit are registered and take effect on the cycle after their pulse, so the bench samples them at the very next falling edge. Stream bytes have no fixed latency, because every header word and every buffer word costs a request and a response on a memory port that the bench throttles. A scoreboard therefore compares each byte, with its last and abort flags, on the cycle it is handed over: the bench samples ready and valid together just after the falling edge that set ready, so the transfer it records is the one at the next rising edge. Causes, write-backs and the final pointer are checked after a settling window well beyond the worst-case chain time, and cause pulses are counted at every falling edge so none is missed.

// File: rtl/tdma_pkg.sv
// Shared constants and state type for the transmit descriptor engine.
// Assumes 32-bit descriptor words in a byte-addressed, word-wide memory.
package tdma_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int OWN_BIT   = 31;   // command/status: descriptor owned by engine
    localparam int LAST_BIT  = 30;   // command/status: descriptor closes the frame
    localparam int CNT_LSB   = 16;   // size word: byte-count field position
    localparam int CNT_W     = 16;   // size word: byte-count field width
    localparam int HDR_WORDS = 4;
    localparam int OFS_CMD   = 4;    // byte offset of command/status

    typedef enum logic [3:0] {
        S_IDLE, S_HREQ, S_HRSP, S_CHECK, S_DREQ, S_DRSP,
        S_BYTE, S_DWB, S_NEXT, S_CLOSE, S_FWB
    } walk_state_t;
endpackage

// File: rtl/tdma_byte_hold.sv
// One-byte hold-back output stage. It keeps the latest byte until either the
// next byte arrives or the frame is closed, so the last flag always lands on
// the true final byte. Assumes in_valid and close are never high together and
// that the producer holds in_valid/in_data until in_ready.
module tdma_byte_hold #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [BW-1:0] in_data,
    output logic          in_ready,
    input  logic          close,
    input  logic          close_abort,
    output logic          idle,
    output logic          out_valid,
    output logic [BW-1:0] out_data,
    output logic          out_last,
    output logic          out_abort,
    input  logic          out_ready
);
    logic          hv;
    logic [BW-1:0] hd;
    logic          fire;

    // Release the held byte when a successor exists or the frame closes.
    always_comb begin
        out_valid = hv && (in_valid || close);
        out_data  = hd;
        out_last  = hv && close;
        out_abort = hv && close && close_abort;
        fire      = out_valid && out_ready;
        in_ready  = !hv || fire;
        idle      = !hv;
    end

    // Hold register: capture a new byte, or empty on a final hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv <= 1'b0;
            hd <= '0;
        end else if (in_valid && in_ready) begin
            hv <= 1'b1;
            hd <= in_data;
        end else if (fire) begin
            hv <= 1'b0;
        end
    end

    a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r9_abort_marks_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> out_last && out_valid);
endmodule

// File: rtl/tdma_walker.sv
// Descriptor chain walker. It reads four header words per descriptor, feeds
// the buffer bytes to the hold stage, writes back ownership, and keeps the
// current pointer, start bit and cause pulses. Assumes one outstanding read:
// the response to an accepted read arrives before the next request.
module tdma_walker
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    output logic              start_bit,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_ready,
    output logic              close,
    output logic              close_abort,
    input  logic              hold_idle,
    output logic              cause_txbuf,
    output logic              cause_txend
);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;
    localparam int                IDX_W    = $clog2(HDR_WORDS);

    walk_state_t       st;
    logic [IDX_W-1:0]  widx;
    logic [ADDR_W-1:0] desc_addr, first_addr, w_next, w_buf, bptr;
    logic [WORD_W-1:0] w_cmd, first_cmd, dword;
    logic [CNT_W-1:0]  w_cnt, remain;
    logic              is_first, any_bytes, abort_f, pass;

    // Drive the memory request and the byte/close signals from the state.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        byte_valid    = (st == S_BYTE);
        byte_data     = dword[{bptr[1:0], 3'b000} +: BYTE_W];
        close         = (st == S_CLOSE);
        close_abort   = abort_f;
        case (st)
            S_HREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_addr + ADDR_W'({widx, 2'b00});
            end
            S_DREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {bptr[ADDR_W-1:2], 2'b00};
            end
            S_DWB: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = desc_addr + ADDR_W'(OFS_CMD);
                mem_req_wdata = w_cmd & ~OWN_MASK;
            end
            S_FWB: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = first_addr + ADDR_W'(OFS_CMD);
                mem_req_wdata = first_cmd & ~OWN_MASK;
            end
            default: ;
        endcase
    end

    // Chain-walk sequencer with software commands and frame-end bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;       widx <= '0;
            desc_addr <= '0;    first_addr <= '0;
            w_next <= '0;       w_buf <= '0;     bptr <= '0;
            w_cmd <= '0;        first_cmd <= '0; dword <= '0;
            w_cnt <= '0;        remain <= '0;
            is_first <= 1'b0;   any_bytes <= 1'b0; abort_f <= 1'b0;
            pass <= 1'b0;       start_bit <= 1'b0; cur_ptr <= '0;
            cause_txbuf <= 1'b0; cause_txend <= 1'b0;
        end else begin
            cause_txbuf <= 1'b0;
            cause_txend <= 1'b0;
            if (ptr_load) cur_ptr <= ptr_value;
            if (cmd_start) begin
                start_bit <= 1'b1;
                pass      <= 1'b1;
            end
            case (st)
                S_IDLE: if (pass) begin
                    if (cur_ptr == '0) begin
                        pass <= 1'b0;
                    end else begin
                        desc_addr  <= cur_ptr;
                        first_addr <= cur_ptr;
                        is_first   <= 1'b1;
                        any_bytes  <= 1'b0;
                        abort_f    <= 1'b0;
                        widx       <= '0;
                        st         <= S_HREQ;
                    end
                end
                S_HREQ: if (mem_req_ready) st <= S_HRSP;
                S_HRSP: if (mem_rsp_valid) begin
                    case (widx)
                        2'd0:    w_cnt  <= mem_rsp_rdata[CNT_LSB +: CNT_W];
                        2'd1:    w_cmd  <= mem_rsp_rdata;
                        2'd2:    w_next <= mem_rsp_rdata[ADDR_W-1:0];
                        default: w_buf  <= mem_rsp_rdata[ADDR_W-1:0];
                    endcase
                    widx <= widx + 1'b1;
                    st   <= (widx == IDX_W'(HDR_WORDS - 1)) ? S_CHECK : S_HREQ;
                end
                S_CHECK: begin
                    if (is_first && !w_cmd[OWN_BIT]) begin
                        pass <= 1'b0;
                        st   <= S_IDLE;
                    end else begin
                        if (is_first) first_cmd <= w_cmd;
                        remain <= w_cnt;
                        bptr   <= w_buf;
                        if (w_cnt != '0) st <= S_DREQ;
                        else             st <= is_first ? S_NEXT : S_DWB;
                    end
                end
                S_DREQ: if (mem_req_ready) st <= S_DRSP;
                S_DRSP: if (mem_rsp_valid) begin
                    dword <= mem_rsp_rdata;
                    st    <= S_BYTE;
                end
                S_BYTE: if (byte_ready) begin
                    any_bytes <= 1'b1;
                    bptr      <= bptr + 1'b1;
                    remain    <= remain - 1'b1;
                    if (remain == CNT_W'(1))   st <= is_first ? S_NEXT : S_DWB;
                    else if (bptr[1:0] == 2'b11) st <= S_DREQ;
                end
                S_DWB: if (mem_req_ready) st <= S_NEXT;
                S_NEXT: begin
                    if (w_cmd[LAST_BIT]) begin
                        st <= S_CLOSE;
                    end else if (w_next == '0) begin
                        abort_f <= 1'b1;
                        st      <= S_CLOSE;
                    end else begin
                        desc_addr <= w_next;
                        is_first  <= 1'b0;
                        widx      <= '0;
                        st        <= S_HREQ;
                    end
                end
                S_CLOSE: if (hold_idle) st <= S_FWB;
                S_FWB: if (mem_req_ready) begin
                    cur_ptr     <= w_next;
                    cause_txbuf <= any_bytes && !abort_f;
                    if (abort_f || w_next == '0) begin
                        cause_txend <= 1'b1;
                        start_bit   <= 1'b0;
                        pass        <= 1'b0;
                    end
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
        && $stable(mem_req_we));
    a_r6_wb_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> !mem_req_wdata[OWN_BIT]);
    a_r11_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
        cause_txend |=> !start_bit);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cause_txbuf |=> !cause_txbuf);
endmodule

// File: rtl/tdma_tx_engine.sv
// Top of the linked-descriptor transmit DMA engine: the chain walker feeding
// a one-byte hold-back output stage. Assumes a word-wide memory that answers
// reads in order, one at a time.
module tdma_tx_engine
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    output logic              start_bit,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_abort,
    output logic              cause_txbuf,
    output logic              cause_txend
);
    logic              byte_valid, byte_ready, close, close_abort, hold_idle;
    logic [BYTE_W-1:0] byte_data;

    tdma_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .ptr_load(ptr_load), .ptr_value(ptr_value),
        .start_bit(start_bit), .cur_ptr(cur_ptr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .close(close), .close_abort(close_abort), .hold_idle(hold_idle),
        .cause_txbuf(cause_txbuf), .cause_txend(cause_txend)
    );

    tdma_byte_hold #(.BW(BYTE_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .in_valid(byte_valid), .in_data(byte_data), .in_ready(byte_ready),
        .close(close), .close_abort(close_abort), .idle(hold_idle),
        .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last),
        .out_abort(tx_abort), .out_ready(tx_ready)
    );
endmodule

// File: tb/tdma_tx_engine_bench.sv
`timescale 1ns/100ps
module tdma_tx_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0, ptr_load = 1'b0;
    logic [31:0] ptr_value = '0;
    logic        start_bit;
    logic [31:0] cur_ptr;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        tx_valid, tx_last, tx_abort, cause_txbuf, cause_txend;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;

    int checks = 0, fails = 0, cyc = 0;
    int n_txbuf = 0, n_txend = 0, n_wr = 0, n_req = 0;
    bit done = 1'b0;
    logic [31:0] mem [0:1023];
    logic [9:0]  exp_q [$];   // {abort, last, data}

    always #2.5 clk = ~clk;   // 200 MHz

    tdma_tx_engine u_tdma_tx_engine (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .start_bit(start_bit), .cur_ptr(cur_ptr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .tx_abort(tx_abort),
        .cause_txbuf(cause_txbuf), .cause_txend(cause_txend)
    );

    function automatic logic [7:0] bval(int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: one-cycle read latency, throttled acceptance.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            n_req <= n_req + 1;
            if (mem_req_we) begin
                mem[mem_req_addr[11:2]] <= mem_req_wdata;
                n_wr <= n_wr + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[11:2]];
            end
        end
        mem_req_ready <= (cyc % 5) != 1;
    end

    // Monitor: throttles ready, then scores the byte handed over next edge.
    always @(negedge clk) begin
        if (cause_txbuf) n_txbuf++;
        if (cause_txend) n_txend++;
        tx_ready = (cyc % 7) != 3 && (cyc % 7) != 4;
        #1;
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5 unexpected byte actual=%h expected=none", tx_data);
            end else begin
                chk("R5/R9 stream byte {abort,last,data}",
                    {22'd0, tx_abort, tx_last, tx_data}, {22'd0, exp_q.pop_front()});
            end
        end
    end

    // Driver helpers: build descriptors and push expected bytes.
    task automatic set_desc(int a, int cnt, bit own, bit last, int nxt, int bufp);
        mem[a >> 2]       = (32'(cnt) << 16) | 32'h0000_00C3;
        mem[(a >> 2) + 1] = (32'(own) << 31) | (32'(last) << 30) | 32'h5;
        mem[(a >> 2) + 2] = 32'(nxt);
        mem[(a >> 2) + 3] = 32'(bufp);
    endtask

    task automatic push_bytes(int bufp, int cnt, bit term, bit abrt);
        for (int i = 0; i < cnt; i++) begin
            bit fin = term && (i == cnt - 1);
            exp_q.push_back({fin && abrt, fin, bval(bufp + i)});
        end
    endtask

    task automatic pulse_ptr(int v);
        @(negedge clk); ptr_load = 1'b1; ptr_value = 32'(v);
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic finish_run();
        chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int b0, e0, w0, r0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 256; i < 320; i++)
            mem[i] = {bval(4*i+3), bval(4*i+2), bval(4*i+1), bval(4*i)};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 start_bit", 32'(start_bit), 0);
        chk("R1 cur_ptr", cur_ptr, 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 mem_req_valid", 32'(mem_req_valid), 0);
        chk("R1 causes", {30'd0, cause_txbuf, cause_txend}, 0);

        // R2: start with null pointer
        pulse_start();
        chk("R13 start_bit one cycle after start", 32'(start_bit), 1);
        repeat (30) @(negedge clk);
        chk("R2 no memory request", 32'(n_req), 0);
        chk("R2 no cause", 32'(n_txbuf + n_txend), 0);

        // R4 R5 R6 R8 R12: two frames then a non-owned descriptor
        set_desc('h100, 5, 1, 0, 'h110, 'h400);
        set_desc('h110, 3, 1, 1, 'h120, 'h413);
        set_desc('h120, 4, 1, 0, 'h1A0, 'h422);
        set_desc('h1A0, 0, 1, 1, 'h130, 'h000);
        set_desc('h130, 2, 0, 1, 'h000, 'h440);
        push_bytes('h400, 5, 0, 0);
        push_bytes('h413, 3, 1, 0);
        push_bytes('h422, 4, 1, 0);
        pulse_ptr('h100);
        chk("R13 cur_ptr one cycle after load", cur_ptr, 32'h100);
        pulse_start();
        repeat (600) @(negedge clk);
        chk("R10 two frames sent", 32'(n_txbuf), 2);
        chk("R12 no end cause mid-chain", 32'(n_txend), 0);
        chk("R11 cur_ptr at stopping descriptor", cur_ptr, 32'h130);
        chk("R12 start_bit still set", 32'(start_bit), 1);
        chk("R7 first desc OWN cleared", mem['h104 >> 2], 32'h5);
        chk("R6 second desc OWN cleared", mem['h114 >> 2], 32'h4000_0005);
        chk("R7 frame-2 first desc OWN cleared", mem['h124 >> 2], 32'h5);
        chk("R6 zero-length tail OWN cleared", mem['h1A4 >> 2], 32'h4000_0005);
        chk("R12 non-owned desc untouched", mem['h134 >> 2], 32'h4000_0005);
        chk("R5 all frame bytes seen", 32'(exp_q.size()), 0);

        // R10 R11: zero-length frame ending the chain
        b0 = n_txbuf; e0 = n_txend;
        set_desc('h140, 0, 1, 1, 'h000, 'h000);
        pulse_ptr('h140);
        pulse_start();
        repeat (200) @(negedge clk);
        chk("R10 zero-length frame no txbuf", 32'(n_txbuf - b0), 0);
        chk("R11 txend on null next", 32'(n_txend - e0), 1);
        chk("R11 start_bit cleared", 32'(start_bit), 0);
        chk("R11 cur_ptr null", cur_ptr, 0);
        chk("R7 zero-length first OWN cleared", mem['h144 >> 2], 32'h4000_0005);

        // R9: abort on null next before last
        b0 = n_txbuf; e0 = n_txend;
        set_desc('h150, 3, 1, 0, 'h160, 'h430);
        set_desc('h160, 2, 1, 0, 'h000, 'h441);
        push_bytes('h430, 3, 0, 0);
        push_bytes('h441, 2, 1, 1);
        pulse_ptr('h150);
        pulse_start();
        repeat (400) @(negedge clk);
        chk("R9 no txbuf on abort", 32'(n_txbuf - b0), 0);
        chk("R9 txend on abort", 32'(n_txend - e0), 1);
        chk("R9 start_bit cleared", 32'(start_bit), 0);
        chk("R7 aborted first OWN cleared", mem['h154 >> 2], 32'h5);
        chk("R6 aborted second OWN cleared", mem['h164 >> 2], 32'h5);

        // R3: first descriptor not owned
        b0 = n_txbuf; e0 = n_txend; w0 = n_wr; r0 = n_req;
        set_desc('h170, 4, 0, 1, 'h180, 'h400);
        pulse_ptr('h170);
        pulse_start();
        repeat (100) @(negedge clk);
        chk("R3 no write", 32'(n_wr - w0), 0);
        chk("R3 header only read", 32'(n_req - r0), 4);
        chk("R3 no cause", 32'(n_txbuf - b0 + n_txend - e0), 0);
        chk("R3 cur_ptr unchanged", cur_ptr, 32'h170);
        chk("R3 cmd untouched", mem['h174 >> 2], 32'h4000_0005);

        done = 1'b1;
        finish_run();
    end
endmodule